// File: doc/BRIEF.md
# Serial Frame Aligner and Payload Descrambler

This block sits behind the clock and data recovery of a fixed-latency optical link receiver. It accepts the recovered line one bit per clock, qualified by a valid input. It searches the bit stream for the 8-bit frame header, which marks the start of each 88-bit frame. It then confirms the boundary over several frames and declares lock. While locked it takes each frame apart into a header, a 64-bit scrambled payload and a 16-bit parity field.

Each frame taken while locked produces one result. The parity field is checked through syndromes of two interleaved Reed-Solomon codes over GF(16), and the payload is restored by a self-synchronizing descrambler. The result is presented as a 64-bit word with a one-cycle strobe, a flag that tells data frames from idle frames, and an error flag. Two static inputs switch off the parity check and the descrambler, each on its own. A run of bad headers drops lock, and the search then restarts one bit further on.

Top module: `rx_frame_decoder`

## Requirements
- R1: A frame is 88 bits sent most significant bit first: an 8-bit header, then the 64-bit scrambled payload (bit 63 first), then the 16-bit parity field. Header 0x5A marks a data frame and 0xA5 marks an idle frame; any other value is a header error.
- R2: While searching, the aligner tests every bit position. `lock_o` rises on the 4th consecutive frame whose header is valid at the candidate boundary, and never before.
- R3: While locked, 8 consecutive header errors drop `lock_o`. A valid header clears the error run, and 7 consecutive errors keep lock.
- R4: After a drop, the search resumes one bit position further on and relocks on a correctly framed stream.
- R5: `data_stb_o` is a one-cycle pulse, once per frame, only while `lock_o` is high. The frame that completes lock is output; the frame that drops lock is not.
- R6: The descrambler computes out[n] = in[n] ^ in[n-39] ^ in[n-58] over the received scrambled payload bit sequence (polynomial x^58+x^39+1), and the history carries across frames.
- R7: Because the feedback uses received bits, the first word output after lock is already correct.
- R8: `is_data_o` is 1 for a frame with header 0x5A and 0 for any other header.
- R9: The 80-bit code word is {payload, parity}. Nibble k is bits [4k+3:4k]; even k belong to code A and odd k to code B, at position k/2. Each code must satisfy S0 = sum of c_i = 0 and S1 = sum of c_i*alpha^i = 0 over GF(16) with x^4+x+1 and alpha = 2. `err_o` is 1 if any syndrome is nonzero, and the data still passes through.
- R10: With `rs_bypass_i` high when a frame is taken, `err_o` is 0 for that frame.
- R11: With `scr_bypass_i` high, `data_o` equals the received scrambled payload.
- R12: Cycles with `bit_vld_i` low neither shift the stream nor advance the frame position.
- R13: After reset, `lock_o`, `data_stb_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_i | input | 1 | Serial line bit |
| bit_vld_i | input | 1 | bit_i carries a new bit this cycle |
| rs_bypass_i | input | 1 | Disable the parity check |
| scr_bypass_i | input | 1 | Disable the descrambler |
| data_o | output | 64 | Decoded payload word |
| data_stb_o | output | 1 | One-cycle strobe per decoded word |
| is_data_o | output | 1 | 1 for a data frame, 0 for idle or a bad header |
| lock_o | output | 1 | Frame aligner is locked |
| err_o | output | 1 | Parity syndrome nonzero for this word |

## Verification
The assertions assume that the bypass inputs only change between frames, and that frames are at least 88 valid bits apart, which the serial input enforces by itself. The bench changes a bypass only after an idle cycle that follows the last bit of a frame. It sends zero filler before frames, so that during a search no header value can appear across a filler/frame seam. After a deliberate loss of lock, it pads with 200 zero bits before framing resumes, so that a false candidate found in stale payload bits fails on zeros before the real headers arrive. The bench inserts a gap cycle with the valid input low every thirteenth bit.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int FRAME_W  = 88;
    localparam int HDR_W    = 8;
    localparam int PAY_W    = 64;
    localparam int PAR_W    = 16;
    localparam int CODE_W   = PAY_W + PAR_W;
    localparam int SYM_W    = 4;
    localparam int N_SYM    = CODE_W / SYM_W;
    localparam int N_INTL   = 2;
    localparam int CODE_LEN = N_SYM / N_INTL;
    localparam int TAP_A    = 39;
    localparam int TAP_B    = 58;

    localparam logic [HDR_W-1:0] HDR_DATA = 8'h5A;
    localparam logic [HDR_W-1:0] HDR_IDLE = 8'hA5;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_VERIFY,
        ST_LOCKED
    } align_st_e;

    typedef struct packed {
        logic [PAY_W-1:0] pay;
        logic [PAR_W-1:0] par;
    } code_word_t;

    typedef struct packed {
        logic [HDR_W-1:0] hdr;
        code_word_t       cw;
    } frame_t;

    // GF(16) product, field polynomial x^4 + x + 1
    function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                                input logic [SYM_W-1:0] b);
        logic [SYM_W-1:0] acc;
        logic [SYM_W-1:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[SYM_W-2:0], 1'b0} ^ (sh[SYM_W-1] ? 4'b0011 : 4'b0000);
        end
        return acc;
    endfunction

    function automatic logic [SYM_W-1:0] gf_alpha_pow(input int n);
        logic [SYM_W-1:0] r;
        r = 4'h1;
        for (int i = 0; i < 16; i++) begin
            if (i < n) r = gf_mul(r, 4'h2);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxf_aligner.sv
module rxf_aligner
    import rxf_pkg::*;
#(
    parameter int LOCK_N = 4,
    parameter int LOSS_N = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   bit_i,
    input  logic   vld_i,
    output frame_t frame_o,
    output logic   chk_o,
    output logic   accept_o,
    output logic   lock_o
);

    localparam int CNT_W  = $clog2(FRAME_W);
    localparam int GOOD_W = $clog2(LOCK_N + 1);
    localparam int MISS_W = $clog2(LOSS_N + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] sr_q, sr_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [GOOD_W-1:0]  good_q, good_d;
    logic [MISS_W-1:0]  miss_q, miss_d;
    align_st_e          st_q, st_d;
    logic               hdr_ok;

    assign sr_d    = {sr_q[FRAME_W-2:0], bit_i};
    assign frame_o = frame_t'(sr_d);
    assign hdr_ok  = (frame_o.hdr == HDR_DATA) || (frame_o.hdr == HDR_IDLE);

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        good_d = good_q;
        miss_d = miss_q;
        chk_o  = 1'b0;
        if (vld_i) begin
            if (cnt_q == CNT_LAST) begin
                chk_o = 1'b1;
                cnt_d = '0;
                unique case (st_q)
                    ST_HUNT: begin
                        if (hdr_ok) begin
                            st_d   = ST_VERIFY;
                            good_d = GOOD_W'(1);
                        end else begin
                            cnt_d = cnt_q;  // test the next bit position
                        end
                    end
                    ST_VERIFY: begin
                        if (hdr_ok) begin
                            if (good_q == GOOD_W'(LOCK_N - 1)) begin
                                st_d   = ST_LOCKED;
                                good_d = '0;
                            end else begin
                                good_d = good_q + GOOD_W'(1);
                            end
                        end else begin
                            st_d   = ST_HUNT;
                            good_d = '0;
                            cnt_d  = cnt_q;
                        end
                    end
                    ST_LOCKED: begin
                        if (hdr_ok) begin
                            miss_d = '0;
                        end else if (miss_q == MISS_W'(LOSS_N - 1)) begin
                            st_d   = ST_HUNT;
                            miss_d = '0;
                            cnt_d  = cnt_q;  // slip by one bit
                        end else begin
                            miss_d = miss_q + MISS_W'(1);
                        end
                    end
                    default: st_d = ST_HUNT;
                endcase
            end else begin
                cnt_d = cnt_q + CNT_W'(1);
            end
        end
    end

    assign accept_o = chk_o && (st_d == ST_LOCKED);
    assign lock_o   = (st_q == ST_LOCKED);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            cnt_q  <= CNT_LAST;
            good_q <= '0;
            miss_q <= '0;
            st_q   <= ST_HUNT;
        end else begin
            if (vld_i) sr_q <= sr_d;
            cnt_q  <= cnt_d;
            good_q <= good_d;
            miss_q <= miss_d;
            st_q   <= st_d;
        end
    end

    // R12: a cycle without a valid bit leaves the stream untouched
    a_r12_hold_stream: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> $stable(sr_q));

    // R3: the header error run never reaches the drop threshold while held
    a_r3_miss_bound: assert property (@(posedge clk) disable iff (rst)
        miss_q < MISS_W'(LOSS_N));

    // R2: lock is only entered from confirmation
    a_r2_lock_from_verify: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_o) |-> $past(st_q == ST_VERIFY));

endmodule

// File: rtl/rxf_rs_check.sv
module rxf_rs_check
    import rxf_pkg::*;
(
    input  code_word_t cw_i,
    input  logic       byp_i,
    output logic       err_o
);

    logic [CODE_W-1:0] flat;
    logic [N_INTL-1:0] bad;

    assign flat = cw_i;

    for (genvar c = 0; c < N_INTL; c++) begin : g_code
        logic [SYM_W-1:0] s0, s1;
        always_comb begin
            s0 = '0;
            s1 = '0;
            for (int i = 0; i < CODE_LEN; i++) begin
                s0 = s0 ^ flat[(i*N_INTL + c)*SYM_W +: SYM_W];
                s1 = s1 ^ gf_mul(flat[(i*N_INTL + c)*SYM_W +: SYM_W], gf_alpha_pow(i));
            end
        end
        assign bad[c] = |{s0, s1};
    end

    assign err_o = !byp_i && (|bad);

endmodule

// File: rtl/rxf_descrambler.sv
module rxf_descrambler
    import rxf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PAY_W-1:0] word_i,
    input  logic             upd_i,
    input  logic             byp_i,
    output logic [PAY_W-1:0] word_o
);

    localparam int HIST_W = TAP_B;

    logic [HIST_W-1:0]       hist_q;
    logic [PAY_W+HIST_W-1:0] ext;
    logic [PAY_W-1:0]        plain;

    // higher index is earlier on the line; hist_q[0] precedes word_i[63]
    assign ext = {hist_q, word_i};

    for (genvar j = 0; j < PAY_W; j++) begin : g_bit
        assign plain[j] = ext[j] ^ ext[j + TAP_A] ^ ext[j + TAP_B];
    end

    assign word_o = byp_i ? word_i : plain;

    always_ff @(posedge clk) begin
        if (rst)        hist_q <= '0;
        else if (upd_i) hist_q <= word_i[HIST_W-1:0];
    end

endmodule

// File: rtl/rx_frame_decoder.sv
module rx_frame_decoder
    import rxf_pkg::*;
#(
    parameter int LOCK_N = 4,
    parameter int LOSS_N = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bit_i,
    input  logic        bit_vld_i,
    input  logic        rs_bypass_i,
    input  logic        scr_bypass_i,
    output logic [63:0] data_o,
    output logic        data_stb_o,
    output logic        is_data_o,
    output logic        lock_o,
    output logic        err_o
);

    frame_t           frm;
    logic             chk, accept, rs_err;
    logic [PAY_W-1:0] desc;

    rxf_aligner #(.LOCK_N(LOCK_N), .LOSS_N(LOSS_N)) u_align (
        .clk      (clk),
        .rst      (rst),
        .bit_i    (bit_i),
        .vld_i    (bit_vld_i),
        .frame_o  (frm),
        .chk_o    (chk),
        .accept_o (accept),
        .lock_o   (lock_o)
    );

    rxf_rs_check u_rs (
        .cw_i  (frm.cw),
        .byp_i (rs_bypass_i),
        .err_o (rs_err)
    );

    rxf_descrambler u_dscr (
        .clk    (clk),
        .rst    (rst),
        .word_i (frm.cw.pay),
        .upd_i  (chk),
        .byp_i  (scr_bypass_i),
        .word_o (desc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o     <= '0;
            data_stb_o <= 1'b0;
            is_data_o  <= 1'b0;
            err_o      <= 1'b0;
        end else begin
            data_stb_o <= accept;
            if (accept) begin
                data_o    <= desc;
                is_data_o <= (frm.hdr == HDR_DATA);
                err_o     <= rs_err;
            end
        end
    end

    // R5: a word is only presented while locked
    a_r5_stb_locked: assert property (@(posedge clk) disable iff (rst)
        data_stb_o |-> lock_o);

    // R5: strobes are single cycles
    a_r5_stb_single: assert property (@(posedge clk) disable iff (rst)
        data_stb_o |=> !data_stb_o);

    // R2: the frame completing lock is output
    a_r2_lock_emits: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_o) |-> data_stb_o);

    // R10: a bypassed check never raises the error flag
    a_r10_bypass_clean: assert property (@(posedge clk) disable iff (rst)
        (data_stb_o && $past(rs_bypass_i)) |-> !err_o);

endmodule

// File: tb/sim_rx_frame_decoder.sv
module sim_rx_frame_decoder;

    logic        clk = 1'b0;
    logic        rst, bit_i, bit_vld_i, rs_bypass_i, scr_bypass_i;
    logic [63:0] data_o;
    logic        data_stb_o, is_data_o, lock_o, err_o;

    always #5 clk = ~clk;

    rx_frame_decoder u0 (
        .clk(clk), .rst(rst), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
        .rs_bypass_i(rs_bypass_i), .scr_bypass_i(scr_bypass_i),
        .data_o(data_o), .data_stb_o(data_stb_o), .is_data_o(is_data_o),
        .lock_o(lock_o), .err_o(err_o)
    );

    int          n_chk = 0;
    int          n_err = 0;
    bit          done  = 0;
    int          bitcnt = 0;
    logic [57:0] th = '0;
    logic [63:0] q_data[$];
    logic        q_isd[$];
    logic        q_err[$];

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] gmul(input logic [3:0] a, input logic [3:0] b);
        logic [7:0] p;
        p = '0;
        for (int i = 0; i < 4; i++) if (b[i]) p = p ^ (8'(a) << i);
        for (int k = 6; k >= 4; k--) if (p[k]) p = p ^ (8'b10011 << (k - 4));
        return p[3:0];
    endfunction

    function automatic logic [3:0] apow(input int n);
        logic [3:0] r;
        r = 4'h1;
        for (int i = 0; i < n; i++) r = gmul(r, 4'h2);
        return r;
    endfunction

    task automatic sample();
        logic [63:0] ed;
        logic        ei, ee;
        if (data_stb_o) begin
            if (q_data.size() == 0) begin
                check(1'b0, "R5 unexpected strobe", 64'd1, 64'd0);
            end else begin
                ed = q_data.pop_front();
                ei = q_isd.pop_front();
                ee = q_err.pop_front();
                check(data_o == ed, "R6 R7 R11 payload", data_o, ed);
                check(is_data_o == ei, "R8 data flag", 64'(is_data_o), 64'(ei));
                check(err_o == ee, "R9 R10 error flag", 64'(err_o), 64'(ee));
            end
        end
    endtask

    task automatic step(input logic b, input logic v);
        @(negedge clk);
        sample();
        bit_i     = b;
        bit_vld_i = v;
    endtask

    task automatic idle(input int n);
        repeat (n) step(1'b0, 1'b0);
    endtask

    // R12: a gap cycle every thirteenth bit
    task automatic send_bit(input logic b);
        step(b, 1'b1);
        bitcnt++;
        if (bitcnt % 13 == 0) step(1'b1, 1'b0);
    endtask

    task automatic send_frame(input logic [63:0] d, input logic [7:0] h,
                              input bit expect_out, input logic [15:0] flip);
        logic [63:0] e;
        logic [79:0] cw;
        logic [87:0] fr;
        logic [3:0]  d0, d1, sym, p0, p1;
        for (int j = 63; j >= 0; j--) begin
            e[j] = d[j] ^ th[38] ^ th[57];
            th   = {th[56:0], e[j]};
        end
        cw = {e, 16'h0000};
        for (int c = 0; c < 2; c++) begin
            d0 = '0;
            d1 = '0;
            p1 = '0;
            for (int i = 2; i < 10; i++) begin
                sym = cw[(2*i + c)*4 +: 4];
                d0  = d0 ^ sym;
                d1  = d1 ^ gmul(sym, apow(i));
            end
            for (int t = 0; t < 16; t++) if (gmul(4'(t), 4'h3) == (d0 ^ d1)) p1 = 4'(t);
            p0 = p1 ^ d0;
            cw[c*4 +: 4]       = p0;
            cw[(2 + c)*4 +: 4] = p1;
        end
        cw[15:0] = cw[15:0] ^ flip;
        if (expect_out) begin
            q_data.push_back(scr_bypass_i ? e : d);
            q_isd.push_back(h == 8'h5A);
            q_err.push_back((flip != 16'h0) && !rs_bypass_i);
        end
        fr = {h, cw};
        for (int k = 87; k >= 0; k--) send_bit(fr[k]);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    task automatic check_lock(input logic exp, input string req);
        idle(1);
        check(lock_o == exp, req, 64'(lock_o), 64'(exp));
    endtask

    initial begin
        rst = 1'b1; bit_i = 1'b0; bit_vld_i = 1'b0;
        rs_bypass_i = 1'b0; scr_bypass_i = 1'b0;
        repeat (3) @(negedge clk);
        check(lock_o == 1'b0, "R13 lock after reset", 64'(lock_o), 64'd0);
        check(data_stb_o == 1'b0, "R13 strobe after reset", 64'(data_stb_o), 64'd0);
        check(err_o == 1'b0, "R13 error after reset", 64'(err_o), 64'd0);
        rst = 1'b0;

        // R1 R2: acquisition from an arbitrary offset
        repeat (37) send_bit(1'b0);
        for (int f = 0; f < 3; f++) send_frame(rnd64(), 8'h5A, 1'b0, 16'h0);
        check_lock(1'b0, "R2 no lock after three headers");
        send_frame(rnd64(), 8'h5A, 1'b1, 16'h0);
        check_lock(1'b1, "R2 lock on fourth header");

        // R6 R7: data frames, then R8 idle frames
        for (int f = 0; f < 6; f++) send_frame(rnd64(), 8'h5A, 1'b1, 16'h0);
        send_frame(64'h0, 8'h5A, 1'b1, 16'h0);
        send_frame(64'hFFFF_FFFF_FFFF_FFFF, 8'h5A, 1'b1, 16'h0);
        for (int f = 0; f < 3; f++) send_frame(rnd64(), 8'hA5, 1'b1, 16'h0);

        // R9: single symbol errors in code A and in code B
        send_frame(rnd64(), 8'h5A, 1'b1, 16'h0004);
        send_frame(rnd64(), 8'h5A, 1'b1, 16'h0020);
        send_frame(rnd64(), 8'hA5, 1'b1, 16'h8000);

        // R10: check bypassed
        idle(1); rs_bypass_i = 1'b1;
        send_frame(rnd64(), 8'h5A, 1'b1, 16'h0100);
        idle(1); rs_bypass_i = 1'b0;

        // R11: descrambler bypassed, then restored
        scr_bypass_i = 1'b1;
        send_frame(rnd64(), 8'h5A, 1'b1, 16'h0);
        send_frame(rnd64(), 8'hA5, 1'b1, 16'h0);
        idle(1); scr_bypass_i = 1'b0;
        send_frame(rnd64(), 8'h5A, 1'b1, 16'h0);

        // R3: seven misses and a good header keep lock
        for (int f = 0; f < 7; f++) send_frame(rnd64(), 8'h3C, 1'b1, 16'h0);
        send_frame(rnd64(), 8'h5A, 1'b1, 16'h0);
        check_lock(1'b1, "R3 error run cleared by valid header");
        for (int f = 0; f < 7; f++) send_frame(rnd64(), 8'h3C, 1'b1, 16'h0);
        check_lock(1'b1, "R3 seven errors keep lock");
        send_frame(rnd64(), 8'h3C, 1'b0, 16'h0);
        check_lock(1'b0, "R3 eighth error drops lock");

        // R4: search resumes and relocks
        repeat (200) send_bit(1'b0);
        for (int f = 0; f < 3; f++) send_frame(rnd64(), 8'h5A, 1'b0, 16'h0);
        check_lock(1'b0, "R4 no lock before fourth header");
        send_frame(rnd64(), 8'hA5, 1'b1, 16'h0);
        check_lock(1'b1, "R4 relock");
        send_frame(rnd64(), 8'h5A, 1'b1, 16'h0);
        send_frame(rnd64(), 8'h5A, 1'b1, 16'h0010);

        idle(5);
        check(q_data.size() == 0, "R5 every locked frame strobed",
              64'(q_data.size()), 64'd0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R5 watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule